// File: doc/BRIEF.md
# Event-Driven PWM Waveform Generator

This block produces one pulse-width-modulated output. A free-running 16-bit counter and two equality comparators generate it. The counter has two modes. In the sawtooth mode it counts down and reloads a programmable period value after it passes zero. In the triangle mode it climbs from zero to the period value and falls back again. In each cycle the block can raise any of six events: the count is zero, the count equals the period value, or one of the two compare values matches the count. A compare match is tagged with the direction of counting in that cycle, so each compare value gives two events.

A 12-bit action word assigns each event its own effect on the output: keep, invert, force low or force high. When several events occur in the same cycle, a fixed priority picks the one event whose action is applied. The output is a flop, so every change shows one clock edge after the cycle in which its event occurred. The surrounding logic drives the configuration inputs and the run enable. Pulse position and duty cycle are set by moving the compare values and by choosing the actions.

Top module: `pwm_event_gen`

## Requirements
- R1: While reset is asserted and after it is released, `count` and `pwm_out` read 0 until `run` is raised.
- R2: With `mode`=0 the counter decrements by one per running cycle. In the cycle after it reads 0 it reads `load_val`.
- R3: With `mode`=1 the counter rises by one per running cycle until it reaches `load_val`. It then falls by one per cycle to 0 and turns upward again, so the period is 2×`load_val` cycles.
- R4: A zero event occurs when `count`==0 and a period event when `count`==`load_val`. A compare event occurs when `count` equals `cmp_a` or `cmp_b`. It is tagged "up" only when `mode`=1 and the counter is rising in that cycle, and otherwise "down". With `mode`=0, up-tagged events never occur.
- R5: Each event's action is taken from a fixed field of `act_ctrl`: [1:0] zero, [3:2] period, [5:4] A-up, [7:6] A-down, [9:8] B-up, [11:10] B-down.
- R6: Action codes are 00 keep, 01 invert, 10 drive low and 11 drive high. The new output value appears at the clock edge that ends the event's cycle. In a cycle without events the output holds.
- R7: When a zero or period event occurs in the same cycle as a compare event, only the zero or period action is applied.
- R8: When compare A and compare B events occur in the same cycle, only the compare A action is applied.
- R9: When zero and period events occur together (`load_val`=0), only the zero action is applied.
- R10: While `run` is 0 the counter and the output both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Counter and output enable |
| mode | input | 1 | 0 = count down with reload, 1 = count up then down |
| load_val | input | 16 | Period value |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_ctrl | input | 12 | Six 2-bit action fields |
| count | output | 16 | Current counter value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Every cycle, the assertions check four things. The counter reloads and turns around correctly at its ends. Up-tagged events are absent in sawtooth mode. Idle cycles and stopped cycles hold the output. The winning action is applied when zero, period or compare events coincide. Only the bench scenarios can show that a whole waveform is correct over many periods in both modes. These scenarios cross the action field layout with the comparator placement and include compare values at 0 and at the period value. For that, the bench compares the output and the count cycle by cycle against an independent model. It also runs directed cases with hand-derived results.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  localparam int ACT_W   = 2;
  localparam int N_EVT   = 6;
  localparam int CTRL_W  = ACT_W * N_EVT;

  // Field offsets inside the action word (order fixed by R5)
  localparam int OFS_ZERO = 0;
  localparam int OFS_LOAD = 2;
  localparam int OFS_AUP  = 4;
  localparam int OFS_ADN  = 6;
  localparam int OFS_BUP  = 8;
  localparam int OFS_BDN  = 10;

  typedef enum logic [ACT_W-1:0] {
    ACT_KEEP = 2'b00,
    ACT_INV  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  typedef struct packed {
    logic zero;
    logic load;
    logic a_up;
    logic a_dn;
    logic b_up;
    logic b_dn;
  } evt_t;

endpackage

// File: rtl/pwm_cnt_unit.sv
module pwm_cnt_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  // next-state
  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!mode_i) begin
      up_d  = 1'b0;
      cnt_d = (cnt_q == '0) ? load_i : cnt_q - 1'b1;
    end else if (up_q) begin
      if (cnt_q >= load_i) begin
        up_d  = 1'b0;
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = (load_i == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // registers, clock enable = run_i
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (run_i) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = mode_i & up_q;

  AST_DN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !mode_i && cnt_q == '0) |=> (cnt_q == $past(load_i))); // R2

  AST_UD_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i && up_q && cnt_q == load_i && load_i != '0) |=>
      (!up_q && cnt_q == $past(load_i) - 1'b1)); // R3

  AST_UD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i && !up_q && cnt_q == '0 && load_i != '0) |=> (up_q && cnt_q == 1)); // R3

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output evt_t             evt_o
);

  localparam int N_CMP = 2;

  logic [CNT_W-1:0] cmp_val [N_CMP];
  logic [N_CMP-1:0] hit_up, hit_dn;

  assign cmp_val[0] = cmp_a_i;
  assign cmp_val[1] = cmp_b_i;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    logic eq;
    assign eq        = run_i && (cnt_i == cmp_val[g]);
    assign hit_up[g] = eq &  up_i;
    assign hit_dn[g] = eq & ~up_i;
  end

  always_comb begin
    evt_o      = '0;
    evt_o.zero = run_i && (cnt_i == '0);
    evt_o.load = run_i && (cnt_i == load_i);
    evt_o.a_up = hit_up[0];
    evt_o.a_dn = hit_dn[0];
    evt_o.b_up = hit_up[1];
    evt_o.b_dn = hit_dn[1];
  end

endmodule

// File: rtl/pwm_act_unit.sv
module pwm_act_unit
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  evt_t              evt_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              pwm_o
);

  act_e sel;
  logic pwm_q, pwm_d, hit_any;

  // Fixed priority: zero, period, A-up, A-down, B-up, B-down
  always_comb begin
    if (evt_i.zero)      sel = act_e'(ctrl_i[OFS_ZERO +: ACT_W]);
    else if (evt_i.load) sel = act_e'(ctrl_i[OFS_LOAD +: ACT_W]);
    else if (evt_i.a_up) sel = act_e'(ctrl_i[OFS_AUP  +: ACT_W]);
    else if (evt_i.a_dn) sel = act_e'(ctrl_i[OFS_ADN  +: ACT_W]);
    else if (evt_i.b_up) sel = act_e'(ctrl_i[OFS_BUP  +: ACT_W]);
    else if (evt_i.b_dn) sel = act_e'(ctrl_i[OFS_BDN  +: ACT_W]);
    else                 sel = ACT_KEEP;
  end

  assign hit_any = |evt_i;

  always_comb begin
    unique case (sel)
      ACT_INV:  pwm_d = ~pwm_q;
      ACT_LOW:  pwm_d = 1'b0;
      ACT_HIGH: pwm_d = 1'b1;
      default:  pwm_d = pwm_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwm_q <= 1'b0;
    else if (hit_any) pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0) |=> $stable(pwm_q)); // R6

  AST_ZERO_OVER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.zero && (evt_i.a_dn || evt_i.b_dn || evt_i.a_up || evt_i.b_up) &&
     ctrl_i[OFS_ZERO +: ACT_W] == 2'b11) |=> pwm_q); // R7

  AST_LOAD_OVER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.load && !evt_i.zero && ctrl_i[OFS_LOAD +: ACT_W] == 2'b10) |=> !pwm_q); // R7

  AST_A_OVER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.zero && !evt_i.load && evt_i.a_dn && evt_i.b_dn &&
     ctrl_i[OFS_ADN +: ACT_W] == 2'b11) |=> pwm_q); // R8

  AST_ZERO_OVER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.zero && evt_i.load && ctrl_i[OFS_ZERO +: ACT_W] == 2'b01) |=>
      (pwm_q != $past(pwm_q))); // R9

endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mode,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [CTRL_W-1:0] act_ctrl,
  output logic [CNT_W-1:0]  count,
  output logic              pwm_out
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;
  logic [CNT_W-1:0]       cnt;
  logic                   up;
  evt_t                   evt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  pwm_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_ni),
    .run_i  (run),
    .mode_i (mode),
    .load_i (load_val),
    .cnt_o  (cnt),
    .up_o   (up)
  );

  pwm_cmp_bank #(.CNT_W(CNT_W)) u_cmp (
    .run_i   (run),
    .cnt_i   (cnt),
    .up_i    (up),
    .load_i  (load_val),
    .cmp_a_i (cmp_a),
    .cmp_b_i (cmp_b),
    .evt_o   (evt)
  );

  pwm_act_unit u_act (
    .clk    (clk),
    .rst_n  (rst_ni),
    .evt_i  (evt),
    .ctrl_i (act_ctrl),
    .pwm_o  (pwm_out)
  );

  assign count = cnt;

  AST_DNMODE_NO_UP: assert property (@(posedge clk) disable iff (!rst_ni)
    !mode |-> !(evt.a_up || evt.b_up)); // R4

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> $stable(pwm_out)); // R10

endmodule

// File: tb/pwm_event_gen_bench.sv
`timescale 1ns/1ps
module pwm_event_gen_bench;

  typedef struct packed {
    logic        m;
    logic [15:0] ld;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [11:0] ctl;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd9,  16'd6, 16'd3, 12'h083, 16'd40},
    '{1'b1, 16'd8,  16'd5, 16'd2, 12'h0B0, 16'd50},
    '{1'b1, 16'd10, 16'd3, 16'd7, 12'hB02, 16'd50},
    '{1'b0, 16'd6,  16'd0, 16'd6, 12'h8CD, 16'd30},
    '{1'b1, 16'd7,  16'd4, 16'd4, 12'hE50, 16'd40},
    '{1'b1, 16'd5,  16'd5, 16'd0, 12'hC25, 16'd30},
    '{1'b0, 16'd0,  16'd0, 16'd0, 12'h00D, 16'd10},
    '{1'b1, 16'd0,  16'd0, 16'd0, 12'h00D, 16'd10},
    '{1'b0, 16'd5,  16'd3, 16'd3, 12'hC40, 16'd30},
    '{1'b0, 16'd4,  16'd2, 16'd1, 12'h555, 16'd30},
    '{1'b1, 16'd1,  16'd1, 16'd0, 12'h555, 16'd20},
    '{1'b1, 16'd6,  16'd6, 16'd0, 12'h3FC, 16'd40}
  };

  logic        clk = 1'b0;
  logic        rst_n, run, mode;
  logic [15:0] load_val, cmp_a, cmp_b, count;
  logic [11:0] act_ctrl;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  logic chk_on = 1'b0;

  always #2.5 clk = ~clk;

  pwm_event_gen u_pwm_event_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .load_val(load_val),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .act_ctrl(act_ctrl), .count(count), .pwm_out(pwm_out)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt;
  logic        m_up, m_pwm;
  logic        z, l, upe, au, ad, bu, bd;
  logic [1:0]  act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 16'd0; m_up <= 1'b0; m_pwm <= 1'b0;
    end else if (run) begin
      z   = (m_cnt == 16'd0);
      l   = (m_cnt == load_val);
      upe = mode & m_up;
      au  = (m_cnt == cmp_a) &  upe;
      ad  = (m_cnt == cmp_a) & ~upe;
      bu  = (m_cnt == cmp_b) &  upe;
      bd  = (m_cnt == cmp_b) & ~upe;
      if (z)       act = act_ctrl[1:0];
      else if (l)  act = act_ctrl[3:2];
      else if (au) act = act_ctrl[5:4];
      else if (ad) act = act_ctrl[7:6];
      else if (bu) act = act_ctrl[9:8];
      else if (bd) act = act_ctrl[11:10];
      else         act = 2'b00;
      case (act)
        2'b01:   m_pwm <= ~m_pwm;
        2'b10:   m_pwm <= 1'b0;
        2'b11:   m_pwm <= 1'b1;
        default: m_pwm <= m_pwm;
      endcase
      if (!mode) begin
        m_up  <= 1'b0;
        m_cnt <= (m_cnt == 16'd0) ? load_val : m_cnt - 16'd1;
      end else if (m_up) begin
        if (m_cnt >= load_val) begin
          m_up <= 1'b0; m_cnt <= (m_cnt == 16'd0) ? 16'd0 : m_cnt - 16'd1;
        end else m_cnt <= m_cnt + 16'd1;
      end else begin
        if (m_cnt == 16'd0) begin
          m_up <= 1'b1; m_cnt <= (load_val == 16'd0) ? 16'd0 : 16'd1;
        end else m_cnt <= m_cnt - 16'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 R3 count vs model", count, m_cnt);
      chk("R4 R5 R6 R7 R8 R9 pwm vs model", {15'd0, pwm_out}, {15'd0, m_pwm});
    end
  end

  task automatic setup(input logic m, input logic [15:0] ld, ca, cb, input logic [11:0] ctl);
    @(negedge clk);
    run = 1'b0; mode = m; load_val = ld; cmp_a = ca; cmp_b = cb; act_ctrl = ctl;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] hold_cnt;
    logic        hold_pwm, prev;
    rst_n = 1'b0; run = 1'b0; mode = 1'b0;
    load_val = '0; cmp_a = '0; cmp_b = '0; act_ctrl = '0;

    // R1: reset state
    setup(1'b0, 16'd9, 16'd2, 16'd3, 12'hFFF);
    chk("R1 count after reset", count, 16'd0);
    chk("R1 pwm after reset", {15'd0, pwm_out}, 16'd0);

    // table walk against the model
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].m, VECS[i].ld, VECS[i].ca, VECS[i].cb, VECS[i].ctl);
      run = 1'b1; chk_on = 1'b1;
      repeat (int'(VECS[i].n)) @(negedge clk);
      chk_on = 1'b0; run = 1'b0;
    end

    // R7: zero-high beats A-down-low at count 0
    setup(1'b0, 16'd4, 16'd0, 16'd9, 12'h083);
    run = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      chk("R7 zero wins over compare", {15'd0, pwm_out}, 16'd1);
      @(negedge clk);
    end

    // R8: A-down high beats B-down low on the same count
    setup(1'b0, 16'd6, 16'd3, 16'd3, 12'h8C2);
    run = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (count == 16'd2) chk("R8 A wins over B", {15'd0, pwm_out}, 16'd1);
      if (count == 16'd6) chk("R8 low after zero", {15'd0, pwm_out}, 16'd0);
    end

    // R10: run low holds count and output
    hold_cnt = count; hold_pwm = pwm_out;
    run = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 count held", count, hold_cnt);
      chk("R10 pwm held", {15'd0, pwm_out}, {15'd0, hold_pwm});
    end

    // R9: period 0, zero=invert beats period=high
    setup(1'b0, 16'd0, 16'd7, 16'd7, 12'h00D);
    run = 1'b1;
    prev = pwm_out;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 zero wins over period", {15'd0, pwm_out}, {15'd0, ~prev});
      prev = pwm_out;
    end

    // R4: up-tagged A action never fires in count-down mode
    setup(1'b0, 16'd5, 16'd2, 16'd9, 12'h030);
    run = 1'b1;
    repeat (20) @(negedge clk);
    chk("R4 no up event in down mode", {15'd0, pwm_out}, 16'd0);

    // R5: A-up field at bits 5:4 drives high in up/down mode
    setup(1'b1, 16'd4, 16'd2, 16'd9, 12'h030);
    run = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 A-up field position", {15'd0, pwm_out}, 16'd1);

    // R6: timing of a high action: count 2 rising, output high at the next edge
    setup(1'b1, 16'd6, 16'd2, 16'd9, 12'h030);
    run = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 before event edge", {15'd0, pwm_out}, 16'd0);
    @(negedge clk);
    chk("R6 after event edge", {15'd0, pwm_out}, 16'd1);
    run = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule